// File: doc/BRIEF.md
# Ping-Pong Block Buffer Exchanger

This block holds two equal block buffers between a byte-wide card data engine and a word-wide processor bus port. At any moment one buffer is owned by the card side and the other by the processor side. The card engine writes bytes into its buffer while the processor drains the other buffer one word at a time. A swap command exchanges ownership, so each block can be filled while the previous one is being read out.

A swap also restarts both pointers. The number of complete words the card wrote is handed to the processor side as its readable length. A separate pointer-clear command restarts both pointers without changing ownership. Status outputs show when the card buffer is full and when the processor buffer has been read out. Two sticky error flags record writes that were dropped and reads that found no data.

Top module: `pp_block_exchanger`

## Requirements
- R1: While and after synchronous reset (rst_n low at a clock edge), the card side owns bank 0 (card_bank = 0), card_full = 0, cpu_empty = 1, card_overrun = 0, cpu_underrun = 0 and cpu_rd_data = 0.
- R2: Each accepted swap_req flips card_bank at the next clock edge. The processor side always owns the other bank.
- R3: A swap sets the card byte pointer and the processor word pointer to 0. The processor's readable length becomes floor(bytes written to the outgoing card buffer / LANES).
- R4: Word packing is little-endian. Card byte k of a block appears in word k/LANES, at bits 8*(k mod LANES)+7 down to 8*(k mod LANES).
- R5: cpu_rd_data is registered. A cpu_rd_en accepted at one edge shows the word at the read pointer after that edge, and the pointer advances by one.
- R6: card_full is 1 exactly when BLOCK_BYTES bytes have been written since the last swap, pointer clear or reset.
- R7: cpu_empty is 1 exactly when the read pointer has reached the readable length. For a full block this happens after BLOCK_BYTES/LANES reads.
- R8: A card write while card_full is 1 is dropped and sets card_overrun. card_overrun stays set until reset.
- R9: A processor read while cpu_empty is 1 returns 0, does not move the pointer, and sets cpu_underrun. cpu_underrun stays set until reset.
- R10: ptr_clr sets both pointers to 0. It keeps card_bank and the processor readable length, so the handed-over words can be read again from word 0.
- R11: When swap_req and ptr_clr are both high in one cycle, the result is the same as a swap alone.
- R12: In a cycle with swap_req or ptr_clr high, card_wr_en and cpu_rd_en are ignored. No byte is stored, no pointer moves, no flag changes, and cpu_rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| swap_req | input | 1 | Exchange buffer ownership and restart pointers |
| ptr_clr | input | 1 | Restart pointers, keep ownership |
| card_wr_en | input | 1 | Card-side byte write strobe |
| card_wr_data | input | 8 | Card-side byte |
| cpu_rd_en | input | 1 | Processor-side word read strobe |
| cpu_rd_data | output | 8*LANES | Registered processor-side word |
| card_full | output | 1 | Card buffer holds a full block |
| cpu_empty | output | 1 | Processor buffer has no unread word |
| card_overrun | output | 1 | Sticky: a card write was dropped |
| cpu_underrun | output | 1 | Sticky: a processor read found no data |
| card_bank | output | 1 | Index of the bank the card side owns |

## Verification
The bench builds the block with BLOCK_BYTES = 64 and LANES = 4, which gives 16-word blocks. With this size, random traffic often reaches a full card buffer, overrun writes, fully drained processor buffers and underrun reads. It also mixes in partial blocks, pointer clears and swaps in mid-transfer. Directed cases first fill and drain a whole block to check byte packing. They then issue a pointer clear together with a read, and a swap together with a pointer clear.

// File: rtl/pp_pkg.sv
// Shared definitions for the ping-pong block buffer exchanger.
package pp_pkg;
    // Identifies one of the two buffer banks.
    typedef enum logic {BANK0 = 1'b0, BANK1 = 1'b1} bank_id_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/pp_bank.sv
// One block buffer, stored as words.
// It has a byte-lane write port and an asynchronous word read port.
// Assumes: the caller keeps the addresses in range while it drives the write strobe.
module pp_bank #(
    parameter int WORDS = 128,
    parameter int LANES = 4,
    localparam int WADDR_W = $clog2(WORDS),
    localparam int LANE_W  = $clog2(LANES),
    localparam int WORD_W  = pp_pkg::BYTE_W * LANES
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [WADDR_W-1:0]        wr_word,
    input  logic [LANE_W-1:0]         wr_lane,
    input  logic [pp_pkg::BYTE_W-1:0] wr_byte,
    input  logic [WADDR_W-1:0]        rd_word,
    output logic [WORD_W-1:0]         rd_data
);
    logic [WORD_W-1:0] mem [WORDS];

    // Store one byte into its lane of the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_word][wr_lane*pp_pkg::BYTE_W +: pp_pkg::BYTE_W] <= wr_byte;
        end
    end

    // Present the addressed word to the processor-side mux.
    assign rd_data = mem[rd_word];
endmodule

// File: rtl/pp_card_side.sv
// Card-side byte write pointer.
// It produces the full and overrun status and the word count handed over at a swap.
// Assumes: swap and clr are single-cycle commands; swap has priority over clr.
module pp_card_side #(
    parameter int BLOCK_BYTES = 512,
    parameter int LANES = 4,
    localparam int WORDS   = BLOCK_BYTES / LANES,
    localparam int CNT_W   = $clog2(BLOCK_BYTES + 1),
    localparam int BA_W    = $clog2(BLOCK_BYTES),
    localparam int LANE_W  = $clog2(LANES),
    localparam int WADDR_W = $clog2(WORDS),
    localparam int PTR_W   = $clog2(WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swap,
    input  logic               clr,
    input  logic               wr_en,
    output logic               wr_accept,
    output logic [WADDR_W-1:0] wr_word,
    output logic [LANE_W-1:0]  wr_lane,
    output logic               full,
    output logic               overrun,
    output logic [PTR_W-1:0]   handover_words
);
    logic [CNT_W-1:0] wr_cnt;
    logic             ctl;

    assign ctl       = swap | clr;
    assign full      = (wr_cnt == CNT_W'(BLOCK_BYTES));
    assign wr_accept = wr_en && !ctl && !full;
    assign wr_word   = wr_cnt[BA_W-1:LANE_W];
    assign wr_lane   = wr_cnt[LANE_W-1:0];
    assign handover_words = PTR_W'(wr_cnt >> LANE_W);

    // Advance the byte pointer, restart it on a command, and flag dropped writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt  <= '0;
            overrun <= 1'b0;
        end else if (ctl) begin
            wr_cnt <= '0;
        end else if (wr_en) begin
            if (full) overrun <= 1'b1;
            else      wr_cnt  <= wr_cnt + 1'b1;
        end
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CNT_W'(BLOCK_BYTES));
    a_r3_card_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ctl |=> (wr_cnt == '0));
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    a_r12_no_flag_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ctl |=> $stable(overrun));
endmodule

// File: rtl/pp_cpu_side.sv
// Processor-side word read pointer and registered read data.
// It also produces the empty and underrun status.
// Assumes: rd_in is the word at rd_addr in the bank the processor currently owns.
module pp_cpu_side #(
    parameter int WORDS = 128,
    parameter int WORD_W = 32,
    localparam int WADDR_W = $clog2(WORDS),
    localparam int PTR_W   = $clog2(WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swap,
    input  logic               clr,
    input  logic               rd_en,
    input  logic [PTR_W-1:0]   handover_words,
    input  logic [WORD_W-1:0]  rd_in,
    output logic [WADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data,
    output logic               empty,
    output logic               underrun
);
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] avail;
    logic             ctl;

    assign ctl     = swap | clr;
    assign empty   = !(rd_ptr < avail);
    assign rd_addr = rd_ptr[WADDR_W-1:0];

    // Load the readable length on a swap, restart on a clear, and serve reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            avail    <= '0;
            rd_data  <= '0;
            underrun <= 1'b0;
        end else if (swap) begin
            rd_ptr <= '0;
            avail  <= handover_words;
        end else if (clr) begin
            rd_ptr <= '0;
        end else if (rd_en) begin
            if (!empty) begin
                rd_data <= rd_in;
                rd_ptr  <= rd_ptr + 1'b1;
            end else begin
                rd_data  <= '0;
                underrun <= 1'b1;
            end
        end
    end

    a_r7_ptr_within_len: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= avail);
    a_r9_zero_on_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ctl && empty) |=> (rd_data == '0 && underrun));
    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    a_r12_data_holds_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ctl |=> $stable(rd_data));
endmodule

// File: rtl/pp_block_exchanger.sv
// Top of the ping-pong block buffer exchanger.
// It holds the ownership register, two bank instances, the card-side pointer and the processor-side pointer.
// Assumes: commands and strobes are synchronous to clk; swap_req wins over ptr_clr.
module pp_block_exchanger #(
    parameter int BLOCK_BYTES = 512,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   swap_req,
    input  logic                   ptr_clr,
    input  logic                   card_wr_en,
    input  logic [7:0]             card_wr_data,
    input  logic                   cpu_rd_en,
    output logic [8*LANES-1:0]     cpu_rd_data,
    output logic                   card_full,
    output logic                   cpu_empty,
    output logic                   card_overrun,
    output logic                   cpu_underrun,
    output logic                   card_bank
);
    import pp_pkg::*;

    localparam int WORDS   = BLOCK_BYTES / LANES;
    localparam int WORD_W  = BYTE_W * LANES;
    localparam int WADDR_W = $clog2(WORDS);
    localparam int LANE_W  = $clog2(LANES);
    localparam int PTR_W   = $clog2(WORDS + 1);

    bank_id_e           owner;
    logic               wr_accept;
    logic [WADDR_W-1:0] wr_word;
    logic [LANE_W-1:0]  wr_lane;
    logic [WADDR_W-1:0] rd_addr;
    logic [PTR_W-1:0]   handover_words;
    logic [WORD_W-1:0]  bank_rd [2];
    logic [WORD_W-1:0]  cpu_word;

    // Track which bank the card side owns; every swap flips it.
    always_ff @(posedge clk) begin
        if (!rst_n)        owner <= BANK0;
        else if (swap_req) owner <= (owner == BANK0) ? BANK1 : BANK0;
    end

    assign card_bank = owner;

    // Two identical banks; only the card-owned one takes writes.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        pp_bank #(.WORDS(WORDS), .LANES(LANES)) i_bank (
            .clk     (clk),
            .wr_en   (wr_accept && (owner == bank_id_e'(b))),
            .wr_word (wr_word),
            .wr_lane (wr_lane),
            .wr_byte (card_wr_data),
            .rd_word (rd_addr),
            .rd_data (bank_rd[b])
        );
    end

    // The processor side reads from the bank the card does not own.
    assign cpu_word = (owner == BANK0) ? bank_rd[1] : bank_rd[0];

    pp_card_side #(.BLOCK_BYTES(BLOCK_BYTES), .LANES(LANES)) i_card (
        .clk            (clk),
        .rst_n          (rst_n),
        .swap           (swap_req),
        .clr            (ptr_clr),
        .wr_en          (card_wr_en),
        .wr_accept      (wr_accept),
        .wr_word        (wr_word),
        .wr_lane        (wr_lane),
        .full           (card_full),
        .overrun        (card_overrun),
        .handover_words (handover_words)
    );

    pp_cpu_side #(.WORDS(WORDS), .WORD_W(WORD_W)) i_cpu (
        .clk            (clk),
        .rst_n          (rst_n),
        .swap           (swap_req),
        .clr            (ptr_clr),
        .rd_en          (cpu_rd_en),
        .handover_words (handover_words),
        .rd_in          (cpu_word),
        .rd_addr        (rd_addr),
        .rd_data        (cpu_rd_data),
        .empty          (cpu_empty),
        .underrun       (cpu_underrun)
    );

    a_r2_swap_flips_owner: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req |=> (card_bank != $past(card_bank)));
    a_r10_clear_keeps_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_clr && !swap_req) |=> $stable(card_bank));
    a_r11_swap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_req && ptr_clr) |=> (card_bank != $past(card_bank) && !card_full));
endmodule

// File: tb/test_pp_block_exchanger.sv
`timescale 1ns/1ps
module test_pp_block_exchanger;
    localparam int BB = 64;
    localparam int LN = 4;
    localparam int NW = BB / LN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swap_req = 1'b0, ptr_clr = 1'b0, card_wr_en = 1'b0, cpu_rd_en = 1'b0;
    logic [7:0]  card_wr_data = '0;
    logic [31:0] cpu_rd_data;
    logic        card_full, cpu_empty, card_overrun, cpu_underrun, card_bank;

    int checks = 0;
    int failures = 0;

    // Reference state computed from the requirements.
    logic [7:0]  m_mem [2][BB];
    int          m_owner, m_wr, m_rd, m_avail;
    bit          m_ovr, m_und;
    logic [31:0] m_data;

    pp_block_exchanger #(.BLOCK_BYTES(BB), .LANES(LN)) i_pp_block_exchanger (
        .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .ptr_clr(ptr_clr),
        .card_wr_en(card_wr_en), .card_wr_data(card_wr_data), .cpu_rd_en(cpu_rd_en),
        .cpu_rd_data(cpu_rd_data), .card_full(card_full), .cpu_empty(cpu_empty),
        .card_overrun(card_overrun), .cpu_underrun(cpu_underrun), .card_bank(card_bank)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Little-endian word k of bank b, as packed per R4.
    function automatic logic [31:0] word_of(input int b, input int k);
        return {m_mem[b][4*k+3], m_mem[b][4*k+2], m_mem[b][4*k+1], m_mem[b][4*k]};
    endfunction

    task automatic check_all();
        chk("R2 card_bank", {31'd0, card_bank}, m_owner);
        chk("R6 card_full", {31'd0, card_full}, (m_wr == BB) ? 1 : 0);
        chk("R7 cpu_empty", {31'd0, cpu_empty}, (m_rd >= m_avail) ? 1 : 0);
        chk("R8 card_overrun", {31'd0, card_overrun}, m_ovr);
        chk("R9 cpu_underrun", {31'd0, cpu_underrun}, m_und);
        chk("R4 R5 cpu_rd_data", cpu_rd_data, m_data);
    endtask

    // Apply one cycle of stimulus at a falling edge and advance the model.
    task automatic cycle(input bit sw, input bit cl, input bit we, input logic [7:0] d, input bit re);
        swap_req = sw; ptr_clr = cl; card_wr_en = we; card_wr_data = d; cpu_rd_en = re;
        if (sw) begin
            m_owner = 1 - m_owner; m_avail = m_wr / LN; m_wr = 0; m_rd = 0;
        end else if (cl) begin
            m_wr = 0; m_rd = 0;
        end else begin
            if (we) begin
                if (m_wr < BB) begin m_mem[m_owner][m_wr] = d; m_wr++; end
                else m_ovr = 1;
            end
            if (re) begin
                if (m_rd < m_avail) begin m_data = word_of(1 - m_owner, m_rd); m_rd++; end
                else begin m_data = '0; m_und = 1; end
            end
        end
        @(posedge clk);
        @(negedge clk);
        swap_req = 0; ptr_clr = 0; card_wr_en = 0; cpu_rd_en = 0;
        check_all();
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_owner = 0; m_wr = 0; m_rd = 0; m_avail = 0; m_ovr = 0; m_und = 0; m_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset values are visible while reset is held.
        chk("R1 card_bank", {31'd0, card_bank}, 0);
        chk("R1 card_full", {31'd0, card_full}, 0);
        chk("R1 cpu_empty", {31'd0, cpu_empty}, 1);
        chk("R1 flags", {30'd0, card_overrun, cpu_underrun}, 0);
        chk("R1 cpu_rd_data", cpu_rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill a whole block with a known pattern (R6), then one extra write (R8).
        for (int k = 0; k < BB; k++) cycle(0, 0, 1, 8'(k * 7 + 3), 0);
        chk("R6 full after block", {31'd0, card_full}, 1);
        cycle(0, 0, 1, 8'hEE, 0);
        chk("R8 overrun after extra write", {31'd0, card_overrun}, 1);

        // Swap: owner flips, pointers restart, full block handed over (R2, R3).
        cycle(1, 0, 0, 8'h00, 0);
        chk("R2 owner after swap", {31'd0, card_bank}, 1);
        chk("R3 card pointer restarted", {31'd0, card_full}, 0);
        chk("R3 words readable", {31'd0, cpu_empty}, 0);

        // Drain all words and check little-endian packing (R4, R5, R7).
        for (int k = 0; k < NW; k++) begin
            cycle(0, 0, 0, 8'h00, 1);
            chk("R5 word after read", cpu_rd_data,
                {8'(4*k*7+3+21), 8'(4*k*7+3+14), 8'(4*k*7+3+7), 8'(4*k*7+3)});
        end
        chk("R7 empty after full drain", {31'd0, cpu_empty}, 1);
        cycle(0, 0, 0, 8'h00, 1);
        chk("R9 empty read gives zero", cpu_rd_data, 0);
        chk("R9 underrun set", {31'd0, cpu_underrun}, 1);

        // A read in a clear cycle is ignored; then words re-read from 0 (R10, R12).
        cycle(0, 1, 1, 8'h55, 1);
        chk("R12 data held on clear", cpu_rd_data, 0);
        chk("R10 owner kept", {31'd0, card_bank}, 1);
        chk("R10 readable again", {31'd0, cpu_empty}, 0);
        cycle(0, 0, 0, 8'h00, 1);
        chk("R10 first word again", cpu_rd_data, {8'd24, 8'd17, 8'd10, 8'd3});

        // Partial block of 6 bytes, then swap together with clear (R3, R11).
        for (int k = 0; k < 6; k++) cycle(0, 0, 1, 8'(8'hA0 + k), 0);
        cycle(1, 1, 0, 8'h00, 0);
        chk("R11 swap wins over clear", {31'd0, card_bank}, 0);
        cycle(0, 0, 0, 8'h00, 1);
        chk("R3 partial first word", cpu_rd_data, 32'hA3A2A1A0);
        chk("R3 only whole words handed over", {31'd0, cpu_empty}, 1);

        // Constrained random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            bit sw = (r < 2);
            bit cl = (r >= 2 && r < 3);
            bit we = ($urandom_range(0, 99) < 60);
            bit re = ($urandom_range(0, 99) < 35);
            cycle(sw, cl, we, 8'($urandom), re);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule